// File: doc/BRIEF.md
# Fault-Avoiding Loop Growth Controller

This controller sets up the intercell links of a grid of identical cells after the cells have been diagnosed. Each cell owns one link selector per side; when two side-by-side cells both select the link on their shared side, the two cells join the same ring. With no links selected, every cell closes on itself. Given a map of good and faulty cells and the grid position of the cell that is wired to the external pads, the controller grows one ring outward from that seed cell. It links only good cells, and it links a cell only if that cell has not joined yet. The links therefore form a spanning tree of the seed's good cluster, and that tree becomes a single ring through every cell of the cluster.

Growth is breadth-first. Frontier cells wait in a queue. Each popped cell probes its neighbours in the fixed order north, east, south, west, and each probe takes one clock. A start pulse clears all previous links and launches a run. When the queue runs dry, `done_o` rises and `count_o` gives the number of cells in the seed's ring. The resulting selector vectors are then shifted into the cells by the external tester. The good map must stay stable while a run is in progress.

Top module: `loop_grow_ctrl`

## Requirements
- R1: After reset, all selector bits are 0 (every cell is its own closed loop), `done_o` is 0, `busy_o` is 0 and `count_o` is 0.
- R2: A start pulse whose seed is faulty, or whose seed column is at least COLS, raises `done_o` on the next clock, with `count_o` = 0 and all selector bits 0.
- R3: When `done_o` rises after a run with a good seed, `count_o` equals the number of good cells that can be reached from the seed through steps between good cells that share a side.
- R4: A selector bit is set only on cells that are good and that belong to the seed's cluster.
- R5: Selector bits are 4 per cell at bits [4*i+3:4*i], where cell index i = row*COLS + col and row 0 is the north edge. Bit 0 selects north (row-1), bit 1 east (col+1), bit 2 south (row+1) and bit 3 west (col-1). A cell's bit toward a neighbour is set exactly when that neighbour's opposite bit is set.
- R6: The active links contain no cycle. When a run ends with count c > 0, the total number of set selector bits is 2*(c-1), and every cluster cell has at least one set bit when c > 1.
- R7: No selector bit points off the grid: north bits on row 0, south bits on the last row, west bits on column 0 and east bits on the last column stay 0.
- R8: A new start pulse given while idle or done discards all links from the previous run before growing the new ring.
- R9: While `done_o` is high and no start pulse arrives, `mux_sel_o`, `count_o` and `done_o` hold their values, even if `good_i` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that launches a run (taken only when not busy) |
| good_i | input | COLS*ROWS | Bit i is 1 when cell i passed diagnosis |
| seed_col_i | input | max(1,clog2(COLS)) | Column of the pad-attached seed cell |
| seed_row_i | input | max(1,clog2(ROWS)) | Row of the pad-attached seed cell |
| mux_sel_o | output | 4*COLS*ROWS | Per-cell link selectors, 4 bits per cell |
| count_o | output | clog2(COLS*ROWS+1) | Number of cells in the seed's ring |
| done_o | output | 1 | Run complete; results valid |
| busy_o | output | 1 | Growth in progress |

## Verification
The hardest case to reach from the ports is a good cell that borders two cells that have already joined, where a careless link rule would close a cycle and split the ring into two. The stimulus produces this case on purpose. A border ring of good cells around a faulty core makes the two growth fronts meet on the far side of the ring, and a fully good grid gives many cells two or more joined neighbours. In each case the link total is checked against the harvested count. A restart from an isolated seed directly after a full-grid run shows whether stale links survive.

// File: rtl/loop_pkg.sv
package loop_pkg;

    // Side codes; the opposite side is the code with bit 1 flipped.
    typedef enum logic [1:0] {
        DIR_N = 2'd0,
        DIR_E = 2'd1,
        DIR_S = 2'd2,
        DIR_W = 2'd3
    } side_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_POP  = 2'd1,
        ST_SCAN = 2'd2,
        ST_DONE = 2'd3
    } grow_st_e;

    function automatic logic [1:0] side_back(input logic [1:0] s);
        return s ^ 2'd2;
    endfunction

endpackage

// File: rtl/loop_step.sv
module loop_step
    import loop_pkg::*;
#(
    parameter int COLS = 4,
    parameter int ROWS = 4,
    localparam int XW = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int YW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic [YW-1:0] row_i,
    input  logic [XW-1:0] col_i,
    input  logic [1:0]    side_i,
    output logic          ok_o,
    output logic [YW-1:0] row_o,
    output logic [XW-1:0] col_o
);

    always_comb begin
        ok_o  = 1'b0;
        row_o = row_i;
        col_o = col_i;
        unique case (side_i)
            DIR_N: begin
                ok_o  = (row_i != '0);
                row_o = row_i - 1'b1;
            end
            DIR_E: begin
                ok_o  = (int'(col_i) < COLS - 1);
                col_o = col_i + 1'b1;
            end
            DIR_S: begin
                ok_o  = (int'(row_i) < ROWS - 1);
                row_o = row_i + 1'b1;
            end
            default: begin
                ok_o  = (col_i != '0);
                col_o = col_i - 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/frontier_fifo.sv
module frontier_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int NW = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clear_i,
    input  logic          push_i,
    input  logic [DW-1:0] data_i,
    input  logic          pop_i,
    output logic [DW-1:0] head_o,
    output logic          empty_o
);

    typedef struct packed {
        logic [PW-1:0] rd;
        logic [PW-1:0] wr;
        logic [NW-1:0] n;
    } ptr_t;

    ptr_t ptr_d, ptr_q, base;
    logic [DW-1:0] mem_q [DEPTH];

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        base  = clear_i ? '0 : ptr_q;
        ptr_d = base;
        if (pop_i && !clear_i) begin
            ptr_d.rd = step(base.rd);
        end
        if (push_i) begin
            ptr_d.wr = step(base.wr);
        end
        ptr_d.n = base.n + NW'(push_i) - NW'(pop_i && !clear_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (push_i) begin
            mem_q[base.wr] <= data_i;
        end
    end

    assign head_o  = mem_q[ptr_q.rd];
    assign empty_o = (ptr_q.n == '0);

    // R3: every good cluster cell is queued exactly once, so the queue never overflows
    assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && !clear_i && !(pop_i)) |-> (int'(ptr_q.n) < DEPTH));

    // R3: the controller pops only when the frontier holds a cell
    assert_no_underflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pop_i && !clear_i) |-> (ptr_q.n != '0));

endmodule

// File: rtl/loop_grow_ctrl.sv
module loop_grow_ctrl
    import loop_pkg::*;
#(
    parameter int COLS = 4,
    parameter int ROWS = 4,
    localparam int CELLS = COLS * ROWS,
    localparam int IW = (CELLS > 1) ? $clog2(CELLS) : 1,
    localparam int CW = $clog2(CELLS + 1),
    localparam int XW = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int YW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  logic [CELLS-1:0]   good_i,
    input  logic [XW-1:0]      seed_col_i,
    input  logic [YW-1:0]      seed_row_i,
    output logic [4*CELLS-1:0] mux_sel_o,
    output logic [CW-1:0]      count_o,
    output logic               done_o,
    output logic               busy_o
);

    typedef struct packed {
        grow_st_e                st;
        logic [YW-1:0]           cur_row;
        logic [XW-1:0]           cur_col;
        logic [1:0]              side;
        logic [CELLS-1:0]        visited;
        logic [CELLS-1:0][3:0]   links;
        logic [CW-1:0]           count;
        logic                    done;
    } ctrl_t;

    ctrl_t s_d, s_q;

    logic              q_clear, q_push, q_pop, q_empty;
    logic [YW+XW-1:0]  q_wdata, q_head;
    logic              nb_ok;
    logic [YW-1:0]     nb_row;
    logic [XW-1:0]     nb_col;
    logic [IW-1:0]     cur_idx, nb_idx, seed_idx;
    logic              seed_in, seed_ok;

    function automatic logic [IW-1:0] cell_of(input logic [YW-1:0] r, input logic [XW-1:0] c);
        return IW'(r) * IW'(COLS) + IW'(c);
    endfunction

    loop_step #(.COLS(COLS), .ROWS(ROWS)) i_step (
        .row_i  (s_q.cur_row),
        .col_i  (s_q.cur_col),
        .side_i (s_q.side),
        .ok_o   (nb_ok),
        .row_o  (nb_row),
        .col_o  (nb_col)
    );

    frontier_fifo #(.DEPTH(CELLS), .DW(YW + XW)) i_frontier (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (q_clear),
        .push_i  (q_push),
        .data_i  (q_wdata),
        .pop_i   (q_pop),
        .head_o  (q_head),
        .empty_o (q_empty)
    );

    assign cur_idx  = cell_of(s_q.cur_row, s_q.cur_col);
    assign nb_idx   = cell_of(nb_row, nb_col);
    assign seed_in  = (int'(seed_col_i) < COLS) && (int'(seed_row_i) < ROWS);
    assign seed_idx = seed_in ? cell_of(seed_row_i, seed_col_i) : '0;
    assign seed_ok  = seed_in && good_i[seed_idx];

    always_comb begin
        s_d     = s_q;
        q_clear = 1'b0;
        q_push  = 1'b0;
        q_pop   = 1'b0;
        q_wdata = {nb_row, nb_col};
        unique case (s_q.st)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    s_d.links   = '0;
                    s_d.visited = '0;
                    s_d.count   = '0;
                    s_d.done    = 1'b0;
                    q_clear     = 1'b1;
                    if (seed_ok) begin
                        s_d.visited[seed_idx] = 1'b1;
                        s_d.count             = CW'(1);
                        q_push                = 1'b1;
                        q_wdata               = {seed_row_i, seed_col_i};
                        s_d.st                = ST_POP;
                    end else begin
                        s_d.done = 1'b1;
                        s_d.st   = ST_DONE;
                    end
                end
            end
            ST_POP: begin
                if (q_empty) begin
                    s_d.done = 1'b1;
                    s_d.st   = ST_DONE;
                end else begin
                    q_pop       = 1'b1;
                    s_d.cur_row = q_head[YW+XW-1:XW];
                    s_d.cur_col = q_head[XW-1:0];
                    s_d.side    = DIR_N;
                    s_d.st      = ST_SCAN;
                end
            end
            default: begin
                if (nb_ok && good_i[nb_idx] && !s_q.visited[nb_idx]) begin
                    s_d.visited[nb_idx]                   = 1'b1;
                    s_d.links[cur_idx][s_q.side]          = 1'b1;
                    s_d.links[nb_idx][side_back(s_q.side)] = 1'b1;
                    s_d.count                             = s_q.count + 1'b1;
                    q_push                                = 1'b1;
                end
                s_d.side = s_q.side + 1'b1;
                if (s_q.side == DIR_W) begin
                    s_d.st = ST_POP;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign mux_sel_o = s_q.links;
    assign count_o   = s_q.count;
    assign done_o    = s_q.done;
    assign busy_o    = (s_q.st == ST_POP) || (s_q.st == ST_SCAN);

    // R2: a faulty or off-grid seed finishes at once with an empty ring
    assert_bad_seed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o && !seed_ok) |=> (done_o && count_o == '0 && mux_sel_o == '0));

    // R6: a finished tree of c cells carries exactly c-1 links, two bits each
    assert_tree_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && count_o != '0) |-> ($countones(mux_sel_o) == 2 * (int'(count_o) - 1)));

    // R9: results hold until the next start
    assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !start_i) |=> (done_o && $stable(mux_sel_o) && $stable(count_o)));

    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        localparam int R = i / COLS;
        localparam int C = i % COLS;

        // R7: no link leaves the grid
        assert_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !((R == 0 && mux_sel_o[4*i+0]) || (C == COLS - 1 && mux_sel_o[4*i+1]) ||
              (R == ROWS - 1 && mux_sel_o[4*i+2]) || (C == 0 && mux_sel_o[4*i+3])));

        // R4: while growing, only good cells carry links
        assert_good_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            busy_o |-> (mux_sel_o[4*i+3 -: 4] == 4'b0 || good_i[i]));

        if (C < COLS - 1) begin : g_east
            // R5: east bit pairs with the neighbour's west bit
            assert_pair_ew_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
                mux_sel_o[4*i+1] == mux_sel_o[4*(i+1)+3]);
        end
        if (R < ROWS - 1) begin : g_south
            // R5: south bit pairs with the neighbour's north bit
            assert_pair_ns_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
                mux_sel_o[4*i+2] == mux_sel_o[4*(i+COLS)+0]);
        end
    end

endmodule

// File: tb/test_loop_grow_ctrl.sv
module test_loop_grow_ctrl;

    localparam int COLS  = 5;
    localparam int ROWS  = 4;
    localparam int CELLS = COLS * ROWS;
    localparam int CW    = $clog2(CELLS + 1);
    localparam int XW    = $clog2(COLS);
    localparam int YW    = $clog2(ROWS);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [CELLS-1:0]   good = '0;
    logic [XW-1:0]      seed_c = '0;
    logic [YW-1:0]      seed_r = '0;
    logic [4*CELLS-1:0] sel;
    logic [CW-1:0]      count;
    logic               done, busy;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    loop_grow_ctrl #(.COLS(COLS), .ROWS(ROWS)) i_loop_grow_ctrl (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .start_i    (start),
        .good_i     (good),
        .seed_col_i (seed_c),
        .seed_row_i (seed_r),
        .mux_sel_o  (sel),
        .count_o    (count),
        .done_o     (done),
        .busy_o     (busy)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [CELLS-1:0] reach_of(input logic [CELLS-1:0] g, input int r, input int c);
        logic [CELLS-1:0] rch = '0;
        if (r < ROWS && c < COLS && g[r*COLS+c]) rch[r*COLS+c] = 1'b1;
        for (int k = 0; k < CELLS; k++) begin
            for (int i = 0; i < CELLS; i++) begin
                if (g[i] && !rch[i]) begin
                    if ((i / COLS > 0 && rch[i-COLS]) || (i / COLS < ROWS - 1 && rch[i+COLS]) ||
                        (i % COLS > 0 && rch[i-1]) || (i % COLS < COLS - 1 && rch[i+1]))
                        rch[i] = 1'b1;
                end
            end
        end
        return rch;
    endfunction

    task automatic launch(input logic [CELLS-1:0] g, input int r, input int c);
        @(negedge clk);
        good   = g;
        seed_r = YW'(r);
        seed_c = XW'(c);
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check(done == 1'b1, req, "done within limit", int'(done), 1);
    endtask

    task automatic verify(input logic [CELLS-1:0] g, input int r, input int c, input string tag);
        logic [CELLS-1:0] rch;
        int exp_n, bad4, bad5, bad7, lonely, total;
        rch = reach_of(g, r, c);
        exp_n = $countones(rch);
        bad4 = 0; bad5 = 0; bad7 = 0; lonely = 0; total = $countones(sel);
        for (int i = 0; i < CELLS; i++) begin
            if (sel[4*i+:4] != 4'b0 && !rch[i]) bad4++;
            if (rch[i] && exp_n > 1 && sel[4*i+:4] == 4'b0) lonely++;
            if (i % COLS < COLS - 1 && sel[4*i+1] != sel[4*(i+1)+3]) bad5++;
            if (i / COLS < ROWS - 1 && sel[4*i+2] != sel[4*(i+COLS)+0]) bad5++;
            if ((i / COLS == 0 && sel[4*i+0]) || (i / COLS == ROWS - 1 && sel[4*i+2]) ||
                (i % COLS == 0 && sel[4*i+3]) || (i % COLS == COLS - 1 && sel[4*i+1])) bad7++;
        end
        $display("case %s: cluster %0d", tag, exp_n);
        check(int'(count) == exp_n, "R3", "harvested count", int'(count), exp_n);
        check(bad4 == 0, "R4", "links outside good cluster", bad4, 0);
        check(bad5 == 0, "R5", "unpaired link bits", bad5, 0);
        check(total == 2 * (exp_n - 1), "R6", "link bits (tree)", total, 2 * (exp_n - 1));
        check(lonely == 0, "R6", "cluster cells without link", lonely, 0);
        check(bad7 == 0, "R7", "links off grid", bad7, 0);
    endtask

    task automatic grow_case(input logic [CELLS-1:0] g, input int r, input int c, input string tag);
        launch(g, r, c);
        wait_done("R3");
        verify(g, r, c, tag);
    endtask

    task automatic t_reset;
        check(sel == '0, "R1", "selectors after reset", $countones(sel), 0);
        check(done == 1'b0 && busy == 1'b0, "R1", "done/busy after reset", int'({done, busy}), 0);
        check(count == '0, "R1", "count after reset", int'(count), 0);
    endtask

    task automatic t_full;
        grow_case('1, 1, 2, "full grid");
    endtask

    task automatic t_ring;
        logic [CELLS-1:0] g = '0;
        for (int i = 0; i < CELLS; i++)
            g[i] = (i / COLS == 0) || (i / COLS == ROWS - 1) || (i % COLS == 0) || (i % COLS == COLS - 1);
        grow_case(g, 0, 0, "border ring, cycle avoided");
    endtask

    task automatic t_wall;
        logic [CELLS-1:0] g = '0;
        for (int i = 0; i < CELLS; i++) g[i] = (i % COLS != 2);
        grow_case(g, 3, 1, "faulty column wall");
    endtask

    task automatic t_scatter;
        logic [CELLS-1:0] g = '0;
        for (int i = 0; i < CELLS; i++) g[i] = ((i * 7) % 3) != 0;
        grow_case(g, 0, 1, "scattered faults");
    endtask

    task automatic t_bad_seed;
        logic [CELLS-1:0] g = '1;
        g[2*COLS+2] = 1'b0;
        launch(g, 2, 2);
        check(done == 1'b1 && count == '0, "R2", "faulty seed done/count", int'(count), 0);
        check(sel == '0, "R2", "faulty seed selectors (previous run cleared)", $countones(sel), 0);
        launch('1, 1, 6);
        check(done == 1'b1 && count == '0, "R2", "off-grid seed done/count", int'(count), 0);
        check(sel == '0, "R2", "off-grid seed selectors", $countones(sel), 0);
    endtask

    task automatic t_restart;
        logic [CELLS-1:0] g = '0;
        grow_case('1, 0, 0, "full before restart");
        g[1*COLS+1] = 1'b1;
        g[3*COLS+4] = 1'b1;
        launch(g, 1, 1);
        wait_done("R8");
        check(int'(count) == 1, "R8", "isolated seed count", int'(count), 1);
        check(sel == '0, "R8", "stale links after restart", $countones(sel), 0);
    endtask

    task automatic t_hold;
        logic [4*CELLS-1:0] s0;
        logic [CW-1:0] c0;
        grow_case('1, 2, 3, "hold setup");
        s0 = sel;
        c0 = count;
        @(negedge clk);
        good = 20'h0F0F0;
        repeat (10) @(negedge clk);
        check(sel == s0, "R9", "selectors held", $countones(sel), $countones(s0));
        check(count == c0 && done == 1'b1, "R9", "count held", int'(count), int'(c0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full();
        t_ring();
        t_wall();
        t_scatter();
        t_bad_seed();
        t_restart();
        t_hold();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule